// File: doc/BRIEF.md
# Turn-Off Acknowledge Aggregator

This block runs the power-management turn-off handshake inside a switch that has one upstream side and several downstream ports. A one-cycle turn-off request from the upstream side is fanned out as a one-cycle request pulse on every downstream port that the active-port mask marks as present. The block then waits until each of those ports has returned an acknowledge pulse. When the last one arrives, it emits a single acknowledge pulse toward the upstream side.

Each port's acknowledge is recorded in a received bitmask, and a counter tracks how many distinct ports have answered. The set of ports that must answer is the active mask as sampled in the cycle the request is accepted. While a handshake is open, further requests are dropped. Once the upstream acknowledge has gone out, the block returns to idle with its bitmask and counter cleared. The reset input is asynchronous and active low, and it is expected to be released synchronously to `clk` by the surrounding logic.

Top module: `turnoff_ack_merge`

## Requirements
- R1: During and right after reset, `up_ack_o` is 0 and `dn_req_o` is all zeros.
- R2: A request (`up_req_i`=1) sampled while idle drives `dn_req_o` equal to the sampled `active_mask_i` (bit i = port i) for exactly the one cycle following that edge; otherwise `dn_req_o` is zero.
- R3: `up_ack_o` is a single-cycle pulse, asserted only when every port in the captured mask has acknowledged.
- R4: Repeated acknowledges from one port within a handshake count once and never complete the handshake early.
- R5: Acknowledges from ports outside the captured mask are not counted.
- R6: With a captured mask of zero, `up_ack_o` is asserted in the cycle right after the request edge.
- R7: Acknowledges that arrive while idle, or in the cycle of the request edge itself, are ignored.
- R8: A request that arrives while a handshake is open (including the cycle in which `up_ack_o` is high) is ignored: no broadcast and no extra acknowledge.
- R9: After the `up_ack_o` pulse the block is idle with an empty record, so a new handshake needs fresh acknowledges from all its ports.
- R10: Changes to `active_mask_i` after the request edge do not change which ports must answer.
- R11: `up_ack_o` rises in the cycle after the clock edge that samples the last missing acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_i | input | 1 | Turn-off request pulse from the upstream side |
| up_ack_o | output | 1 | Aggregated acknowledge pulse to the upstream side |
| dn_req_o | output | N_PORTS | Per-port turn-off request pulse |
| dn_ack_i | input | N_PORTS | Per-port acknowledge pulse |
| active_mask_i | input | N_PORTS | Ports that must take part in the handshake |

## Verification
The bench builds the block with `N_PORTS` = 6. With six ports, a random mask leaves some ports outside the handshake often enough to exercise stray acknowledges from inactive ports. The same width also makes mixed orders of arrival frequent: several acknowledges in one cycle, repeats, and one straggler. The zero mask and the all-ones mask come up both in directed steps and in random draws, as do acknowledges aimed at the completion cycle.

// File: rtl/turnoff_pkg.sv
package turnoff_pkg;

  typedef enum logic [0:0] {
    HS_IDLE = 1'b0,
    HS_OPEN = 1'b1
  } hs_state_t;

endpackage

// File: rtl/turnoff_ack_tracker.sv
module turnoff_ack_tracker #(
  parameter int unsigned N_PORTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture_i,
  input  logic               collect_i,
  input  logic               clear_i,
  input  logic [N_PORTS-1:0] active_mask_i,
  input  logic [N_PORTS-1:0] dn_ack_i,
  output logic [N_PORTS-1:0] need_o,
  output logic [N_PORTS-1:0] rcvd_o,
  output logic               all_done_o
);

  localparam int unsigned CW = $clog2(N_PORTS + 1);

  logic [N_PORTS-1:0] need_q;
  logic [N_PORTS-1:0] rcvd_q, rcvd_d;
  logic [N_PORTS-1:0] fresh;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic [CW-1:0]      goal_q, goal_d;
  logic [CW-1:0]      fresh_n;
  logic               cnt_en;

  // per-port bit: set on first ack of a required port
  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign fresh[p] = collect_i & dn_ack_i[p] & need_q[p] & ~rcvd_q[p];

    always_comb begin
      if (clear_i || capture_i) begin
        rcvd_d[p] = 1'b0;
      end else if (fresh[p]) begin
        rcvd_d[p] = 1'b1;
      end else begin
        rcvd_d[p] = rcvd_q[p];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rcvd_q[p] <= 1'b0;
      end else if (clear_i || capture_i || fresh[p]) begin
        rcvd_q[p] <= rcvd_d[p];
      end
    end
  end

  always_comb begin
    fresh_n = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      fresh_n = fresh_n + CW'(fresh[i]);
    end
  end

  always_comb begin
    goal_d = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      goal_d = goal_d + CW'(active_mask_i[i]);
    end
  end

  assign cnt_en = clear_i | capture_i | (|fresh);

  always_comb begin
    if (clear_i || capture_i) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + fresh_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_q <= '0;
      goal_q <= '0;
    end else if (capture_i) begin
      need_q <= active_mask_i;
      goal_q <= goal_d;
    end
  end

  assign need_o     = need_q;
  assign rcvd_o     = rcvd_q;
  assign all_done_o = (cnt_q == goal_q);

  // R5: only required ports are ever recorded
  p_only_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rcvd_q & ~need_q) == '0);

  // R4: counter equals number of distinct ports recorded
  p_count_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CW'($countones(rcvd_q)));

  // R7: nothing is recorded while not collecting
  p_idle_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!collect_i && !capture_i && !clear_i) |=> $stable(rcvd_q));

endmodule

// File: rtl/turnoff_seq_fsm.sv
module turnoff_seq_fsm
  import turnoff_pkg::*;
#(
  parameter int unsigned N_PORTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_req_i,
  input  logic [N_PORTS-1:0] active_mask_i,
  input  logic               all_done_i,
  output logic               capture_o,
  output logic               collect_o,
  output logic               finish_o,
  output logic [N_PORTS-1:0] dn_req_o
);

  hs_state_t          state_q, state_d;
  logic [N_PORTS-1:0] bcast_q, bcast_d;
  logic               bcast_en;

  assign capture_o = (state_q == HS_IDLE) & up_req_i;
  assign finish_o  = (state_q == HS_OPEN) & all_done_i;
  assign collect_o = (state_q == HS_OPEN) & ~all_done_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: if (up_req_i)   state_d = HS_OPEN;
      HS_OPEN: if (all_done_i) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign bcast_d  = capture_o ? active_mask_i : '0;
  assign bcast_en = capture_o | (|bcast_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcast_q <= '0;
    end else if (bcast_en) begin
      bcast_q <= bcast_d;
    end
  end

  assign dn_req_o = bcast_q;

  // R2: broadcast lasts one cycle
  p_bcast_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_req_o) |=> (dn_req_o == '0));

  // R8: no broadcast follows a cycle in which a handshake was open
  p_busy_no_bcast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_OPEN) |=> (dn_req_o == '0));

  // R2: an accepted request opens a handshake
  p_req_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_IDLE && up_req_i) |=> (state_q == HS_OPEN));

endmodule

// File: rtl/turnoff_ack_merge.sv
module turnoff_ack_merge #(
  parameter int unsigned N_PORTS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               up_req_i,
  output logic               up_ack_o,
  output logic [N_PORTS-1:0] dn_req_o,
  input  logic [N_PORTS-1:0] dn_ack_i,
  input  logic [N_PORTS-1:0] active_mask_i
);

  logic               capture;
  logic               collect;
  logic               finish;
  logic               all_done;
  logic [N_PORTS-1:0] need;
  logic [N_PORTS-1:0] rcvd;

  turnoff_seq_fsm #(.N_PORTS(N_PORTS)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_req_i     (up_req_i),
    .active_mask_i(active_mask_i),
    .all_done_i   (all_done),
    .capture_o    (capture),
    .collect_o    (collect),
    .finish_o     (finish),
    .dn_req_o     (dn_req_o)
  );

  turnoff_ack_tracker #(.N_PORTS(N_PORTS)) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture_i    (capture),
    .collect_i    (collect),
    .clear_i      (finish),
    .active_mask_i(active_mask_i),
    .dn_ack_i     (dn_ack_i),
    .need_o       (need),
    .rcvd_o       (rcvd),
    .all_done_o   (all_done)
  );

  assign up_ack_o = finish;

  // R3: upstream ack is a single-cycle pulse
  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack_o |=> !up_ack_o);

  // R3: upstream ack only when every required port has answered
  p_ack_needs_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack_o |-> (rcvd == need));

  // R9: record is empty after the ack
  p_clear_after_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    up_ack_o |=> (rcvd == '0));

endmodule

// File: tb/turnoff_ack_merge_test.sv
`timescale 1ns/1ps
module turnoff_ack_merge_test;

  localparam int unsigned NP = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          up_req;
  logic          up_ack;
  logic [NP-1:0] dn_req;
  logic [NP-1:0] dn_ack;
  logic [NP-1:0] amask;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench reference state
  bit            m_busy = 1'b0;
  logic [NP-1:0] m_need = '0;
  logic [NP-1:0] m_got  = '0;
  int            n_acks = 0;

  always #2.5 clk = ~clk;

  turnoff_ack_merge #(.N_PORTS(NP)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .up_req_i     (up_req),
    .up_ack_o     (up_ack),
    .dn_req_o     (dn_req),
    .dn_ack_i     (dn_ack),
    .active_mask_i(amask)
  );

  function automatic bit exp_ack_now();
    return m_busy && (m_got == m_need);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one cycle, advance the model, check outputs after the edge
  task automatic step(input string tag, input bit req, input logic [NP-1:0] msk,
                      input logic [NP-1:0] ack);
    logic [NP-1:0] e_dn;
    bit            e_ack;
    @(negedge clk);
    up_req = req;
    amask  = msk;
    dn_ack = ack;
    e_dn = '0;
    if (exp_ack_now()) begin
      m_busy = 1'b0;
      m_got  = '0;
    end else if (m_busy) begin
      m_got = m_got | (ack & m_need);
    end else if (req) begin
      m_busy = 1'b1;
      m_need = msk;
      m_got  = '0;
      e_dn   = msk;
    end
    e_ack = exp_ack_now();
    @(posedge clk);
    #1;
    check({tag, " dn_req"}, 32'(dn_req), 32'(e_dn));
    check({tag, " up_ack"}, 32'(up_ack), 32'(e_ack));
    if (up_ack === 1'b1) n_acks++;
  endtask

  initial begin
    rst_n  = 1'b0;
    up_req = 1'b0;
    dn_ack = '0;
    amask  = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset up_ack", 32'(up_ack), 32'd0);
    check("R1 reset dn_req", 32'(dn_req), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1", 1'b0, '0, '0);

    // R6: empty mask, ack one cycle after request
    step("R6", 1'b1, 6'b000000, '0);
    step("R9", 1'b0, '0, '0);

    // R2, R11: all ports; acks in two groups
    step("R2", 1'b1, 6'b111111, 6'b111111);   // acks in request cycle ignored (R7)
    step("R7", 1'b0, 6'b000000, 6'b000111);
    step("R11", 1'b0, 6'b000000, 6'b111000);
    step("R9", 1'b0, '0, 6'b111111);

    // R7: idle acks do not preload
    step("R7", 1'b0, '0, 6'b000011);
    step("R7", 1'b1, 6'b000011, '0);
    step("R7", 1'b0, '0, 6'b000001);
    step("R7", 1'b0, '0, '0);
    step("R3", 1'b0, '0, 6'b000010);
    step("R3", 1'b0, '0, '0);

    // R4: repeats from one port
    step("R4", 1'b1, 6'b000101, '0);
    step("R4", 1'b0, '0, 6'b000001);
    step("R4", 1'b0, '0, 6'b000001);
    step("R4", 1'b0, '0, 6'b000001);
    step("R4", 1'b0, '0, 6'b000100);
    step("R4", 1'b0, '0, '0);

    // R5: inactive ports do not count
    step("R5", 1'b1, 6'b100000, '0);
    step("R5", 1'b0, '0, 6'b011111);
    step("R5", 1'b0, '0, '0);
    step("R5", 1'b0, '0, 6'b100000);
    step("R5", 1'b0, '0, '0);

    // R8 and R10: request and mask change while open
    step("R8", 1'b1, 6'b000110, '0);
    step("R8", 1'b1, 6'b111111, 6'b000010);
    step("R10", 1'b0, 6'b000010, '0);
    step("R10", 1'b1, 6'b000000, 6'b000100);
    step("R8", 1'b1, 6'b111111, '0);   // request during ack cycle ignored
    step("R8", 1'b0, '0, '0);

    // random traffic
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      bit            r;
      logic [NP-1:0] mk;
      logic [NP-1:0] ak;
      r  = ($urandom_range(0, 9) == 0);
      mk = NP'($urandom);
      if ($urandom_range(0, 15) == 0) mk = '0;
      if ($urandom_range(0, 15) == 0) mk = '1;
      ak = NP'($urandom) & NP'($urandom);
      step("R3", r, mk, ak);
    end
    check("R3 acks seen", 32'(n_acks > 10), 32'd1);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule